// File: doc/BRIEF.md
# Chainable Four-Product Multiply-Accumulate Slice

This block multiplies four pairs of signed operands, adds the four products into one wide sum, and then either passes that sum on or folds it into a running 44-bit accumulator. Each accumulate step may add or subtract the new sum. A 44-bit cascade input from an upstream slice is added to this slice's own result. The total is offered at once on a cascade output, so a neighbour can chain on without extra logic, and it is also captured in the registered result port.

The data path has three register levels. The first holds the operands and controls. The second holds the four-product sum. The third is the result and accumulator register. Parameters can bypass the first two levels. The third level is always present, so the accumulator feedback can never form a combinational loop. One clock enable freezes every level, and a synchronous active-high reset clears them.

Top module: `mac4_slice`

## Requirements
- R1: `data_i` carries eight 18-bit two's-complement operands, operand k in bits [18k+17:18k]. Operand 2m is multiplied by operand 2m+1 for m = 0..3. Operands 0..3 form pair adder 0 and operands 4..7 form pair adder 1. The two 37-bit pair results are added into a 38-bit sum Z. With both optional stages present, a sample applied before clock edge e reaches `result_o` after edge e+2, and `cas_i` is added at edge e+2.
- R2: Operand extremes are exact. Eight operands of -131072 give Z = 2^36. Four pairs of (-131072, 131071) give Z = -68718952448.
- R3: When `acc_mode_i`=1 and `clr_i`=0, the new result is the previous result plus Z if `add_sub_i`=1, or minus Z if `add_sub_i`=0, plus `cas_i`.
- R4: When `acc_mode_i`=1 and `clr_i`=1, the result is loaded with plus or minus Z (chosen by `add_sub_i`) plus `cas_i`, and the previous value is dropped.
- R5: When `acc_mode_i`=0, the result is Z plus `cas_i`. `add_sub_i` and the previous result have no effect.
- R6: `cas_o` is this slice's new total including `cas_i`. It is combinational, and `result_o` takes its value at the next enabled edge. A downstream slice fed by `cas_o` adds its own Z to it.
- R7: All 44-bit sums wrap modulo 2^44 without saturation. Z is sign-extended to 44 bits before use.
- R8: While `ce_i`=0, no register changes, including the operand and sum stages. When `ce_i` returns to 1, the pipeline resumes as if the stalled cycles had not occurred.
- R9: A synchronous `rst` clears all stages, so `result_o` and `cas_o` read 0 afterwards when the inputs are 0.
- R10: Parameters `IN_REG` and `PIPE_REG` remove the operand and sum stages, which gives a latency of 1 + IN_REG + PIPE_REG. The result register always stays, and with both removed, accumulation still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Clock enable for all registers |
| data_i | input | 144 | Eight packed signed operands |
| acc_mode_i | input | 1 | 1 = accumulate, 0 = plain sum |
| add_sub_i | input | 1 | 1 = add Z, 0 = subtract Z (accumulate mode only) |
| clr_i | input | 1 | Drop the previous accumulator value |
| cas_i | input | 44 | Cascade input from the upstream slice |
| cas_o | output | 44 | Cascade output to the downstream slice |
| result_o | output | 44 | Registered result and accumulator |

## Verification
The interesting collision is a cascade input arriving in the same cycle as an accumulate, clear or wrap step. In that cycle the accumulator feedback, the signed Z and `cas_i` all meet in one adder. The bench drives non-zero cascade values during mixed add and subtract runs, during clears and across the 2^43 boundary. A second slice receives the first slice's `cas_o` while the first accumulates. Every cycle is judged against a behavioural model of the three-level timing, and explicit constants back up the wrap and clear results.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  typedef struct packed {
    logic acc;
    logic add;
    logic clr;
  } mac4_ctrl_t;
endpackage

// File: rtl/mac4_pipe_reg.sv
module mac4_pipe_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, ce};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac4_pair.sv
module mac4_pair #(
  parameter int OPW = 18
) (
  input  logic signed [OPW-1:0] a0,
  input  logic signed [OPW-1:0] b0,
  input  logic signed [OPW-1:0] a1,
  input  logic signed [OPW-1:0] b1,
  output logic        [2*OPW:0] p
);
  localparam int MW = 2 * OPW;
  logic signed [MW-1:0] m0, m1;
  assign m0 = a0 * b0;
  assign m1 = a1 * b1;
  // one guard bit makes the pair sum exact
  assign p = {m0[MW-1], m0} + {m1[MW-1], m1};
endmodule

// File: rtl/mac4_accum.sv
module mac4_accum
  import mac4_pkg::*;
#(
  parameter int ACCW = 44,
  parameter int ZW   = 38
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic [ZW-1:0]   z,
  input  mac4_ctrl_t      ctrl,
  input  logic [ACCW-1:0] cas_i,
  output logic [ACCW-1:0] cas_o,
  output logic [ACCW-1:0] res_o
);
  logic [ACCW-1:0] z_ext, z_sel, base, res_q;

  assign z_ext = {{(ACCW-ZW){z[ZW-1]}}, z};
  assign z_sel = (ctrl.acc && !ctrl.add) ? (ACCW'(0) - z_ext) : z_ext;
  assign base  = (ctrl.acc && !ctrl.clr) ? res_q : '0;
  assign cas_o = base + z_sel + cas_i;

  // never bypassed: it closes the accumulator loop
  always_ff @(posedge clk) begin
    if (rst)     res_q <= '0;
    else if (ce) res_q <= cas_o;
  end
  assign res_o = res_q;
endmodule

// File: rtl/mac4_slice.sv
module mac4_slice
  import mac4_pkg::*;
#(
  parameter int OPW      = 18,
  parameter int NPAIR    = 2,
  parameter int ACCW     = 44,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_i,
  input  logic [4*NPAIR*OPW-1:0]  data_i,
  input  logic                    acc_mode_i,
  input  logic                    add_sub_i,
  input  logic                    clr_i,
  input  logic [ACCW-1:0]         cas_i,
  output logic [ACCW-1:0]         cas_o,
  output logic [ACCW-1:0]         result_o
);
  localparam int DW = 4 * NPAIR * OPW;
  localparam int PW = 2 * OPW + 1;
  localparam int ZW = PW + $clog2(NPAIR);
  localparam int CW = $bits(mac4_ctrl_t);

  mac4_ctrl_t in_ctrl, s1_ctrl, s2_ctrl;
  logic [DW+CW-1:0] s1_bus;
  logic [DW-1:0]    s1_data;
  logic [PW-1:0]    pair_p [NPAIR];
  logic [ZW-1:0]    z_sum;
  logic [ZW+CW-1:0] s2_bus;
  logic [ZW-1:0]    z_s2;
  logic             s2_acc, s2_clr;

  assign in_ctrl = '{acc: acc_mode_i, add: add_sub_i, clr: clr_i};

  mac4_pipe_reg #(.W(DW+CW), .EN(IN_REG)) u_in_stage (
    .clk(clk), .rst(rst), .ce(ce_i),
    .d({in_ctrl, data_i}), .q(s1_bus)
  );
  assign s1_data = s1_bus[DW-1:0];
  assign s1_ctrl = s1_bus[DW+CW-1:DW];

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      mac4_pair #(.OPW(OPW)) u_pair (
        .a0(s1_data[(4*g+0)*OPW +: OPW]),
        .b0(s1_data[(4*g+1)*OPW +: OPW]),
        .a1(s1_data[(4*g+2)*OPW +: OPW]),
        .b1(s1_data[(4*g+3)*OPW +: OPW]),
        .p (pair_p[g])
      );
    end
  endgenerate

  always_comb begin
    z_sum = '0;
    for (int i = 0; i < NPAIR; i++) begin
      z_sum = z_sum + ZW'($signed(pair_p[i]));
    end
  end

  mac4_pipe_reg #(.W(ZW+CW), .EN(PIPE_REG)) u_sum_stage (
    .clk(clk), .rst(rst), .ce(ce_i),
    .d({s1_ctrl, z_sum}), .q(s2_bus)
  );
  assign z_s2    = s2_bus[ZW-1:0];
  assign s2_ctrl = s2_bus[ZW+CW-1:ZW];
  assign s2_acc  = s2_ctrl.acc;
  assign s2_clr  = s2_ctrl.clr;

  mac4_accum #(.ACCW(ACCW), .ZW(ZW)) u_accum (
    .clk(clk), .rst(rst), .ce(ce_i),
    .z(z_s2), .ctrl(s2_ctrl),
    .cas_i(cas_i), .cas_o(cas_o), .res_o(result_o)
  );
endmodule

// File: rtl/mac4_slice_chk.sv
module mac4_slice_chk #(
  parameter int OPW   = 18,
  parameter int NPAIR = 2,
  parameter int ACCW  = 44,
  parameter int ZW    = 38
) (
  input logic            clk,
  input logic            rst,
  input logic            ce_i,
  input logic [ACCW-1:0] cas_i,
  input logic [ACCW-1:0] cas_o,
  input logic [ACCW-1:0] result_o,
  input logic [ZW-1:0]   z_s2,
  input logic            s2_acc,
  input logic            s2_clr
);
  localparam longint HALF = longint'(1) << (OPW - 1);
  localparam longint ZMAX = longint'(2 * NPAIR) * HALF * HALF;
  localparam longint ZMIN = -(longint'(2 * NPAIR) * HALF * (HALF - 1));

  assert_zsum_range_R2: assert property (@(posedge clk) disable iff (rst)
    (longint'($signed(z_s2)) <= ZMAX) && (longint'($signed(z_s2)) >= ZMIN));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> $stable(result_o));

  assert_cascade_next_R6: assert property (@(posedge clk) disable iff (rst)
    ce_i |=> result_o == $past(cas_o));

  assert_acc_zero_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ce_i && s2_acc && !s2_clr && z_s2 == '0 && cas_i == '0) |=> $stable(result_o));

  assert_plain_no_history_R5: assert property (@(posedge clk) disable iff (rst)
    (ce_i && !s2_acc && z_s2 == '0 && cas_i == '0) |=> result_o == '0);
endmodule

bind mac4_slice mac4_slice_chk #(.OPW(OPW), .NPAIR(NPAIR), .ACCW(ACCW), .ZW(ZW)) u_chk (
  .clk(clk), .rst(rst), .ce_i(ce_i), .cas_i(cas_i), .cas_o(cas_o),
  .result_o(result_o), .z_s2(z_s2), .s2_acc(s2_acc), .s2_clr(s2_clr)
);

// File: tb/tb_mac4_slice.sv
module tb_mac4_slice;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         rst = 1'b1, ce = 1'b1;
  logic [143:0] data = '0, data_b = '0;
  logic         acc = 1'b0, as = 1'b1, clr = 1'b0;
  logic [43:0]  cas = '0;
  logic [43:0]  cas_o, res, b_cas, b_res, nb_cas, nb_res;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  mac4_slice dut (.clk(clk), .rst(rst), .ce_i(ce), .data_i(data), .acc_mode_i(acc),
    .add_sub_i(as), .clr_i(clr), .cas_i(cas), .cas_o(cas_o), .result_o(res));
  mac4_slice dut_b (.clk(clk), .rst(rst), .ce_i(ce), .data_i(data_b), .acc_mode_i(1'b0),
    .add_sub_i(1'b1), .clr_i(1'b0), .cas_i(cas_o), .cas_o(b_cas), .result_o(b_res));
  mac4_slice #(.IN_REG(1'b0), .PIPE_REG(1'b0)) dut_nb (.clk(clk), .rst(rst), .ce_i(ce),
    .data_i(data), .acc_mode_i(acc), .add_sub_i(as), .clr_i(clr), .cas_i(cas),
    .cas_o(nb_cas), .result_o(nb_res));

  function automatic logic [43:0] zsum(logic [143:0] d);
    longint s = 0;
    for (int k = 0; k < 4; k++)
      s += longint'($signed(d[2*k*18 +: 18])) * longint'($signed(d[(2*k+1)*18 +: 18]));
    return s[43:0];
  endfunction

  function automatic logic [143:0] mk(int o0, int o1, int o2, int o3, int o4, int o5, int o6, int o7);
    int o [8] = '{o0, o1, o2, o3, o4, o5, o6, o7};
    logic [143:0] d;
    for (int k = 0; k < 8; k++) d[k*18 +: 18] = 18'(o[k]);
    return d;
  endfunction

  function automatic logic [143:0] rnd();
    logic [143:0] d;
    for (int k = 0; k < 8; k++) d[k*18 +: 18] = 18'($urandom());
    return d;
  endfunction

  // behavioural timing model: operand level, sum level, result level
  logic [143:0] m1_d = '0, mb1_d = '0;
  logic         m1_acc = 0, m1_as = 0, m1_clr = 0, m2_acc = 0, m2_as = 0, m2_clr = 0;
  logic [43:0]  m2_z = '0, mb2_z = '0, m_w = '0, mb_w = '0;
  always @(posedge clk) begin : model
    logic [43:0] nw;
    if (rst) begin
      m1_d <= '0; mb1_d <= '0; m1_acc <= 0; m1_as <= 0; m1_clr <= 0;
      m2_acc <= 0; m2_as <= 0; m2_clr <= 0; m2_z <= '0; mb2_z <= '0; m_w <= '0; mb_w <= '0;
    end else if (ce) begin
      nw = ((m2_acc && !m2_clr) ? m_w : 44'd0)
         + ((m2_acc && !m2_as) ? (44'd0 - m2_z) : m2_z) + cas;
      m_w <= nw; mb_w <= nw + mb2_z;
      m2_z <= zsum(m1_d); mb2_z <= zsum(mb1_d);
      m2_acc <= m1_acc; m2_as <= m1_as; m2_clr <= m1_clr;
      m1_d <= data; mb1_d <= data_b; m1_acc <= acc; m1_as <= as; m1_clr <= clr;
    end
  end

  task automatic check(string tag, logic [43:0] act, logic [43:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk); @(negedge clk);
    check(tag, res, m_w);
  endtask

  task automatic set(logic [143:0] d, logic a, logic s, logic c, logic [43:0] k);
    data = d; acc = a; as = s; clr = c; cas = k;
  endtask

  task automatic t_reset();
    check("R9 reset result", res, 44'd0);
    check("R9 reset cascade", cas_o, 44'd0);
  endtask

  task automatic t_plain();
    set(mk(3, 5, -2, 7, 100, -4, 0, 9), 1'b0, 1'b0, 1'b0, 44'd0);
    repeat (3) tick("R5 plain");
    check("R1 packed sum", res, 44'd0 - 44'd399);
    for (int i = 0; i < 10; i++) begin
      set(rnd(), 1'b0, 1'($urandom()), 1'($urandom()), 44'd0);
      tick("R1 random plain");
    end
    set(mk(1, 1, 0, 0, 0, 0, 0, 0), 1'b0, 1'b0, 1'b0, 44'd0);
    repeat (3) tick("R5 no history");
    check("R5 add_sub ignored", res, 44'd1);
  endtask

  task automatic t_signed();
    set(mk(-131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072),
        1'b0, 1'b1, 1'b0, 44'd0);
    repeat (3) tick("R2 extreme");
    check("R2 max positive", res, 44'd68719476736);
    set(mk(-131072, 131071, -131072, 131071, -131072, 131071, -131072, 131071),
        1'b0, 1'b1, 1'b0, 44'd0);
    repeat (3) tick("R2 extreme");
    check("R2 most negative", res, 44'd0 - 44'd68718952448);
  endtask

  task automatic t_accum();
    set(rnd(), 1'b1, 1'b1, 1'b1, 44'd0);
    tick("R4 clear");
    for (int i = 0; i < 40; i++) begin
      set(rnd(), 1'b1, 1'($urandom()), 1'b0, (i % 5 == 0) ? 44'($urandom()) : 44'd0);
      tick("R3 accumulate");
    end
    set(mk(5, 1, 0, 0, 0, 0, 0, 0), 1'b1, 1'b1, 1'b0, 44'd0);
    repeat (6) tick("R3 steady add");
  endtask

  task automatic t_clear();
    set(mk(1, 1, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, 1'b1, 44'd0);
    repeat (3) tick("R4 clear subtract");
    check("R4 cleared to minus Z", res, 44'hFFF_FFFF_FFFF);
  endtask

  task automatic t_wrap();
    set(mk(1, 1, 0, 0, 0, 0, 0, 0), 1'b0, 1'b1, 1'b0, 44'h7FF_FFFF_FFFF);
    repeat (3) tick("R7 wrap");
    check("R7 wraps past 2^43", res, 44'h800_0000_0000);
    set(mk(-1, 1, 0, 0, 0, 0, 0, 0), 1'b1, 1'b1, 1'b1, 44'h800_0000_0000);
    repeat (3) tick("R7 wrap low");
    check("R7 wraps below -2^43", res, 44'h7FF_FFFF_FFFF);
  endtask

  task automatic t_cascade();
    logic [43:0] seen;
    for (int i = 0; i < 8; i++) begin
      set(rnd(), 1'($urandom()), 1'($urandom()), 1'b0, {12'($urandom()), 32'($urandom())});
      data_b = rnd();
      #1 seen = cas_o;
      @(posedge clk); @(negedge clk);
      check("R6 result takes cas_o", res, seen);
      check("R6 result model", res, m_w);
      check("R6 chained slice", b_res, mb_w);
    end
    set('0, 1'b0, 1'b1, 1'b0, 44'd0); data_b = '0;
    repeat (3) tick("R6 drain");
    check("R6 downstream drained", b_res, 44'd0);
  endtask

  task automatic t_stall();
    logic [43:0] held;
    set(rnd(), 1'b1, 1'b1, 1'b0, 44'd0);
    tick("R8 pre");
    set(rnd(), 1'b1, 1'b0, 1'b0, 44'd7);
    tick("R8 pre");
    ce = 1'b0; held = res;
    for (int i = 0; i < 5; i++) begin
      set(rnd(), 1'($urandom()), 1'($urandom()), 1'($urandom()), 44'($urandom()));
      tick("R8 frozen model");
      check("R8 frozen result", res, held);
    end
    ce = 1'b1;
    set(rnd(), 1'b1, 1'b1, 1'b0, 44'd0);
    repeat (4) tick("R8 resume");
  endtask

  task automatic t_bypass();
    logic [143:0] d1, d2;
    d1 = rnd(); d2 = rnd();
    set(d1, 1'b0, 1'b0, 1'b0, 44'd1234);
    #1 check("R10 cascade through bypass", nb_cas, zsum(d1) + 44'd1234);
    @(posedge clk); @(negedge clk);
    check("R10 latency one", nb_res, zsum(d1) + 44'd1234);
    set(d1, 1'b1, 1'b1, 1'b1, 44'd0);
    @(posedge clk); @(negedge clk);
    check("R10 clear bypass", nb_res, zsum(d1));
    set(d2, 1'b1, 1'b0, 1'b0, 44'd0);
    @(posedge clk); @(negedge clk);
    check("R10 R3 subtract bypass", nb_res, zsum(d1) - zsum(d2));
  endtask

  task automatic t_midreset();
    set(rnd(), 1'b1, 1'b1, 1'b0, 44'd99);
    repeat (3) tick("R9 load");
    rst = 1'b1; set('0, 1'b0, 1'b1, 1'b0, 44'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears", res, 44'd0);
    check("R9 reset clears bypass", nb_res, 44'd0);
    check("R9 cascade zero", cas_o, 44'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_plain();
    t_signed();
    t_accum();
    t_clear();
    t_wrap();
    t_cascade();
    t_stall();
    t_bypass();
    t_midreset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule